// File: doc/BRIEF.md
# Port Read-Modify-Write Unit

This block is one 8-bit general-purpose I/O port of a small microcontroller, as the core sees it. It keeps the output latch that drives the port pins. It also takes in the external pin levels through a two-stage synchronizer. The core presents an operation code, a byte operand, a bit index and a carry bit. The unit answers with read data, a single-bit result and a nonzero flag in the same cycle. It writes any new latch value at the next rising clock edge.

Reads split into two paths. A plain input read, of a byte or of a bit, returns the synchronized pin levels. Every operation that modifies the port takes its source value from the output latch instead. This covers the byte logic and arithmetic operations and the single-bit operations. Because of this, a pin that an external load holds low cannot corrupt the byte that is written back. A bit operation reads the whole latch byte, alters one bit and writes the full byte back. Jump-and-clear reports the old bit as its branch condition.

Top module: `port_rmw_unit`

## Requirements
- R1: After reset the latch reads 0xFF and both synchronizer stages hold all ones, so a plain byte read returns 0xFF.
- R2: Operation codes are: 0 none, 1 pin byte read, 2 pin bit read, 3 AND, 4 OR, 5 XOR, 6 increment, 7 decrement, 8 decrement-and-test, 9 complement bit, 10 clear bit, 11 set bit, 12 move carry to bit, 13 jump-if-set-and-clear. Codes 14 and 15 do nothing.
- R3: Codes 1 and 2 return pin levels that have passed through two clock edges of synchronization. On rd_data_o this is the byte. On bit_o it is bit bit_idx_i.
- R4: Codes 3 to 13 drive rd_data_o with the current latch byte, whatever the pins show. Codes 9 to 13 also drive bit_o with latch bit bit_idx_i. A latch bit at 1 with its pin held low therefore reads as 1.
- R5: AND, OR and XOR combine the latch with operand_i and store the result.
- R6: Increment and decrement add or subtract one with modulo-256 wrap.
- R7: Decrement-and-test stores latch minus one and raises nz_o when that result is nonzero.
- R8: Complement, clear, set and move-carry change only latch bit bit_idx_i and leave the other seven bits as they were.
- R9: Jump-if-set-and-clear drives bit_o with the latch bit before the clear, then clears that bit.
- R10: The latch changes only at the rising edge on which op_valid_i is high with a modifying code. Codes 0, 1, 2, 14 and 15, or op_valid_i low, leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | External pin levels |
| op_valid_i | input | 1 | Operation accepted this cycle |
| op_i | input | 4 | Operation code |
| operand_i | input | 8 | Operand for byte logic operations |
| bit_idx_i | input | 3 | Addressed bit |
| carry_i | input | 1 | Carry for move-carry-to-bit |
| latch_o | output | 8 | Output latch driving the pins |
| rd_data_o | output | 8 | Read byte (pins or latch, by operation) |
| bit_o | output | 1 | Read bit or branch condition |
| nz_o | output | 1 | Decremented value nonzero |

## Verification
The assertions assume that op_i, bit_idx_i and carry_i are stable and known from one falling clock edge to the next, and that op_valid_i is high for only one cycle per operation. The bench changes every input at the falling edge and drops op_valid_i before the next operation, so each update is seen separately. Pin changes are held for at least three edges before a pin read is judged. The one exception is the test that checks the synchronizer delay on purpose.

// File: rtl/port_rmw_pkg.sv
package port_rmw_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP     = 4'd0,
    OP_RD_BYTE = 4'd1,
    OP_RD_BIT  = 4'd2,
    OP_AND     = 4'd3,
    OP_OR      = 4'd4,
    OP_XOR     = 4'd5,
    OP_INC     = 4'd6,
    OP_DEC     = 4'd7,
    OP_DJNZ    = 4'd8,
    OP_CPL     = 4'd9,
    OP_CLR     = 4'd10,
    OP_SET     = 4'd11,
    OP_MOVC    = 4'd12,
    OP_JBC     = 4'd13
  } port_op_e;

  function automatic logic is_byte_mod(logic [OP_W-1:0] op);
    return op >= OP_AND && op <= OP_DJNZ;
  endfunction

  function automatic logic is_bit_mod(logic [OP_W-1:0] op);
    return op >= OP_CPL && op <= OP_JBC;
  endfunction
endpackage

// File: rtl/port_pin_sync.sv
module port_pin_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d_i;
      else             stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/port_rmw_alu.sv
module port_rmw_alu
  import port_rmw_pkg::*;
#(
  parameter int unsigned W    = 8,
  parameter int unsigned IDXW = $clog2(W)
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    cur_i,
  input  logic [W-1:0]    operand_i,
  input  logic [IDXW-1:0] idx_i,
  input  logic            carry_i,
  output logic [W-1:0]    nxt_o,
  output logic            wr_o,
  output logic            old_bit_o,
  output logic            nz_o
);
  logic [W-1:0] mask, dec_val;

  assign mask      = W'(1) << idx_i;
  assign dec_val   = cur_i - W'(1);
  assign old_bit_o = cur_i[idx_i];
  assign nz_o      = (dec_val != '0);
  assign wr_o      = is_byte_mod(op_i) || is_bit_mod(op_i);

  always_comb begin
    nxt_o = cur_i;
    unique case (op_i)
      OP_AND:          nxt_o = cur_i & operand_i;
      OP_OR:           nxt_o = cur_i | operand_i;
      OP_XOR:          nxt_o = cur_i ^ operand_i;
      OP_INC:          nxt_o = cur_i + W'(1);
      OP_DEC, OP_DJNZ: nxt_o = dec_val;
      OP_CPL:          nxt_o = cur_i ^ mask;
      OP_CLR, OP_JBC:  nxt_o = cur_i & ~mask;
      OP_SET:          nxt_o = cur_i | mask;
      OP_MOVC:         nxt_o = carry_i ? (cur_i | mask) : (cur_i & ~mask);
      default:         nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/port_rmw_unit.sv
module port_rmw_unit
  import port_rmw_pkg::*;
#(
  parameter int unsigned W    = 8,
  parameter int unsigned IDXW = $clog2(W)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [W-1:0]    pin_i,
  input  logic            op_valid_i,
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    operand_i,
  input  logic [IDXW-1:0] bit_idx_i,
  input  logic            carry_i,
  output logic [W-1:0]    latch_o,
  output logic [W-1:0]    rd_data_o,
  output logic            bit_o,
  output logic            nz_o
);
  localparam logic [W-1:0] LATCH_RST = '1;

  logic [W-1:0] pin_s, latch_q, latch_d;
  logic         alu_wr, alu_old_bit, alu_nz;

  port_pin_sync #(.W(W), .STAGES(2), .RST_VAL(LATCH_RST)) i_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(pin_s)
  );

  port_rmw_alu #(.W(W), .IDXW(IDXW)) i_alu (
    .op_i, .cur_i(latch_q), .operand_i, .idx_i(bit_idx_i), .carry_i,
    .nxt_o(latch_d), .wr_o(alu_wr), .old_bit_o(alu_old_bit), .nz_o(alu_nz)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                latch_q <= LATCH_RST;
    else if (op_valid_i && alu_wr) latch_q <= latch_d;
  end

  // pin reads use the synchronizer; modify ops read the latch
  always_comb begin
    rd_data_o = '0;
    bit_o     = 1'b0;
    if (op_i == OP_RD_BYTE) begin
      rd_data_o = pin_s;
    end else if (op_i == OP_RD_BIT) begin
      bit_o = pin_s[bit_idx_i];
    end else if (is_byte_mod(op_i)) begin
      rd_data_o = latch_q;
    end else if (is_bit_mod(op_i)) begin
      rd_data_o = latch_q;
      bit_o     = alu_old_bit;
    end
  end

  assign nz_o    = (op_i == OP_DJNZ) && alu_nz;
  assign latch_o = latch_q;
endmodule

// File: rtl/port_rmw_checker.sv
module port_rmw_checker
  import port_rmw_pkg::*;
#(
  parameter int unsigned W    = 8,
  parameter int unsigned IDXW = $clog2(W)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [W-1:0]    pin_i,
  input logic            op_valid_i,
  input logic [OP_W-1:0] op_i,
  input logic [W-1:0]    operand_i,
  input logic [IDXW-1:0] bit_idx_i,
  input logic            carry_i,
  input logic [W-1:0]    latch_o,
  input logic [W-1:0]    rd_data_o,
  input logic            bit_o,
  input logic            nz_o
);
  logic unused;
  assign unused = ^{pin_i, operand_i, carry_i, bit_o};

  assert_hold_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> $stable(latch_o));

  assert_modify_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_byte_mod(op_i) || is_bit_mod(op_i)) |-> rd_data_o == latch_o);

  assert_one_bit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && is_bit_mod(op_i)) |=>
      ((latch_o ^ $past(latch_o)) & ~(W'(1) << $past(bit_idx_i))) == '0);

  assert_jbc_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == OP_JBC) |=> latch_o[$past(bit_idx_i)] == 1'b0);

  assert_djnz_store_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == OP_DJNZ) |=> latch_o == W'($past(latch_o) - W'(1)));

  assert_djnz_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_DJNZ) |-> nz_o == (latch_o != W'(1)));
endmodule

bind port_rmw_unit port_rmw_checker #(.W(W), .IDXW(IDXW)) i_chk (.*);

// File: tb/test_port_rmw_unit.sv
`timescale 1ns/1ps
module test_port_rmw_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] pin_i = 8'hFF;
  logic       op_valid_i = 1'b0;
  logic [3:0] op_i = 4'd0;
  logic [7:0] operand_i = 8'h00;
  logic [2:0] bit_idx_i = 3'd0;
  logic       carry_i = 1'b0;
  logic [7:0] latch_o, rd_data_o;
  logic       bit_o, nz_o;

  int n_chk = 0, n_fail = 0;
  logic [7:0] last_rd;
  logic       last_bit, last_nz;
  bit         done = 0;

  always #2.5 clk_i = ~clk_i;

  port_rmw_unit i_port_rmw_unit (.*);

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [3:0] op, input logic [7:0] opd,
                       input logic [2:0] idx, input logic c);
    @(negedge clk_i);
    op_i = op; operand_i = opd; bit_idx_i = idx; carry_i = c; op_valid_i = 1'b1;
    #1;
    last_rd = rd_data_o; last_bit = bit_o; last_nz = nz_o;
    @(negedge clk_i);
    op_valid_i = 1'b0; op_i = 4'd0;
  endtask

  task automatic set_pins(input logic [7:0] v);
    @(negedge clk_i); pin_i = v;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic t_reset;
    chk("R1 latch", latch_o, 8'hFF);
    @(negedge clk_i); op_i = 4'd1; #1;
    chk("R1 sync", rd_data_o, 8'hFF);
    op_i = 4'd0;
  endtask

  task automatic t_pin_read;
    @(negedge clk_i); pin_i = 8'h5A; op_i = 4'd1; #1;
    chk("R3 no edge", rd_data_o, 8'hFF);
    @(negedge clk_i); #1;
    chk("R3 one edge", rd_data_o, 8'hFF);
    @(negedge clk_i); #1;
    chk("R3 two edges", rd_data_o, 8'h5A);
    op_i = 4'd2; bit_idx_i = 3'd1; #1;
    chk("R3 bit1", bit_o, 1);
    bit_idx_i = 3'd2; #1;
    chk("R3 bit2", bit_o, 0);
    op_i = 4'd0;
  endtask

  task automatic t_modify_src;
    set_pins(8'h00);
    do_op(4'd11, 8'h00, 3'd3, 1'b0);
    chk("R4 bit from latch", last_bit, 1);
    chk("R4 byte from latch", last_rd, 8'hFF);
    do_op(4'd2, 8'h00, 3'd3, 1'b0);
    chk("R3 pin low", last_bit, 0);
    do_op(4'd4, 8'h00, 3'd0, 1'b0);
    chk("R4 OR keeps ones", latch_o, 8'hFF);
  endtask

  task automatic t_byte_logic;
    do_op(4'd3, 8'h3C, 3'd0, 1'b0); chk("R5 AND", latch_o, 8'h3C);
    do_op(4'd4, 8'h81, 3'd0, 1'b0); chk("R5 OR", latch_o, 8'hBD);
    do_op(4'd5, 8'hFF, 3'd0, 1'b0); chk("R5 XOR", latch_o, 8'h42);
  endtask

  task automatic t_incdec;
    do_op(4'd6, 8'h00, 3'd0, 1'b0); chk("R6 inc", latch_o, 8'h43);
    do_op(4'd3, 8'h00, 3'd0, 1'b0);
    do_op(4'd7, 8'h00, 3'd0, 1'b0); chk("R6 dec wrap", latch_o, 8'hFF);
    do_op(4'd6, 8'h00, 3'd0, 1'b0); chk("R6 inc wrap", latch_o, 8'h00);
  endtask

  task automatic t_djnz;
    do_op(4'd4, 8'h02, 3'd0, 1'b0);
    do_op(4'd8, 8'h00, 3'd0, 1'b0);
    chk("R7 nz 2->1", last_nz, 1); chk("R7 store 1", latch_o, 8'h01);
    do_op(4'd8, 8'h00, 3'd0, 1'b0);
    chk("R7 nz 1->0", last_nz, 0); chk("R7 store 0", latch_o, 8'h00);
    do_op(4'd8, 8'h00, 3'd0, 1'b0);
    chk("R7 nz 0->FF", last_nz, 1); chk("R7 store FF", latch_o, 8'hFF);
  endtask

  task automatic t_bit_ops;
    do_op(4'd3, 8'h00, 3'd0, 1'b0);
    do_op(4'd11, 8'h00, 3'd5, 1'b0); chk("R8 set", latch_o, 8'h20);
    do_op(4'd9, 8'h00, 3'd0, 1'b0);  chk("R8 cpl0", latch_o, 8'h21);
    do_op(4'd9, 8'h00, 3'd5, 1'b0);  chk("R8 cpl5", latch_o, 8'h01);
    do_op(4'd12, 8'h00, 3'd7, 1'b1); chk("R8 movc1", latch_o, 8'h81);
    do_op(4'd12, 8'h00, 3'd0, 1'b0); chk("R8 movc0", latch_o, 8'h80);
    do_op(4'd10, 8'h00, 3'd7, 1'b0); chk("R8 clr", latch_o, 8'h00);
  endtask

  task automatic t_jbc;
    do_op(4'd4, 8'h12, 3'd0, 1'b0);
    do_op(4'd13, 8'h00, 3'd4, 1'b0);
    chk("R9 cond set", last_bit, 1); chk("R9 cleared", latch_o, 8'h02);
    do_op(4'd13, 8'h00, 3'd4, 1'b0);
    chk("R9 cond clear", last_bit, 0); chk("R9 unchanged", latch_o, 8'h02);
  endtask

  task automatic t_idle;
    @(negedge clk_i);
    op_i = 4'd5; operand_i = 8'hFF; op_valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R10 invalid", latch_o, 8'h02);
    op_i = 4'd0;
    do_op(4'd15, 8'hFF, 3'd1, 1'b1); chk("R2 code15", latch_o, 8'h02);
    do_op(4'd14, 8'hFF, 3'd1, 1'b1); chk("R2 code14", latch_o, 8'h02);
    do_op(4'd1, 8'hFF, 3'd1, 1'b1);  chk("R10 read", latch_o, 8'h02);
    do_op(4'd0, 8'hFF, 3'd1, 1'b1);  chk("R10 nop", latch_o, 8'h02);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_pin_read();
    t_modify_src();
    t_byte_logic();
    t_incdec();
    t_djnz();
    t_bit_ops();
    t_jbc();
    t_idle();
    finish_run();
  end
endmodule